// File: doc/BRIEF.md
# Banked UART Host Register File

This block is the processor-facing register file of a classic 16450/16550-class serial port. A host reaches it through a 3-bit register address, separate read and write strobes and an 8-bit data bus. Each access is decoded onto one of twelve registers. The two lowest addresses are banked: a select bit held in the top bit of the line control register switches them between the data/interrupt-enable pair and the two halves of the baud divisor. At address 2, a read returns the interrupt identification code and a write goes to the FIFO control register.

The serial engine, baud generator, FIFOs and modem pins are not part of this block. They appear as simple ports. A received byte arrives with a load pulse, line errors arrive as pulse flags, and the transmitter reports that it has taken the holding byte with a done pulse. Modem inputs are sampled as levels. The block tracks the pending interrupt sources and masks each with its enable bit. It reports the highest-priority source in the identification code and drives one interrupt line, which is gated by an output-control bit of modem control.

Read data is combinational from the address. Side effects of a read (clearing flags) take place at the clock edge that ends the read strobe.

Top module: `uart_regbank`

## Requirements
- R1: After synchronous reset, the following all read 0: interrupt enable, line control, modem control, FIFO control, scratch, both divisor bytes and the receive buffer. Identification reads 0x01, line status reads 0x60, `irq` and `tx_load` are 0, and `divisor` is 0.
- R2: With line control bit 7 at 0, a write to address 0 produces the following in the next cycle: `tx_load` is 1 for that one cycle, `tx_data` holds the written byte, and line status bits 5 and 6 (holding empty, transmitter empty) are cleared. A `tx_done` pulse sets bits 5 and 6 again.
- R3: With line control bit 7 at 1, address 0 reads and writes the low divisor byte and address 1 reads and writes the high divisor byte. `divisor` = {high, low}, and any 16-bit value is held. These writes neither load the transmitter nor change interrupt enable.
- R4: Address 2 ignores the bank bit. A write sets `fifo_ctrl` and has no effect on what a read returns. A read returns {4'b0, code}.
- R5: Addresses 3 to 7 (line control, modem control, line status, modem status, scratch) ignore the bank bit. Line control and scratch read back 8 bits, and modem control reads back its low 5 bits. A line status write loads its bits 4..1. A modem status write loads its bits 3..0.
- R6: Line status bit 0 (data ready) is set by `rx_load`, which also captures `rx_data` into the receive buffer. A read of address 0 with the bank bit at 0 returns the buffer and clears data ready, unless `rx_load` occurs in the same cycle.
- R7: The `rx_err` bits 0..3 (overrun, parity, framing, break) set line status bits 1..4. These bits stay set until a line status read clears them.
- R8: Modem status bits 7..4 show `modem_in` 3..0. Bits 3..0 record a change of the matching input since the previous cycle and stay set until a modem status read clears them.
- R9: The identification code reports the highest pending enabled source. In priority order the codes are: line error 0x6, data ready 0x4, holding empty 0x2, modem change 0x0. With no source pending the code is 0x1.
- R10: Interrupt enable bit 0 masks data ready, bit 1 masks holding empty, bit 2 masks line errors and bit 3 masks modem change. A masked source neither appears in the identification code nor raises `irq`.
- R11: A `tx_done` pulse makes the holding-empty source pending. It is cleared by a write of the transmit holding register, or by an identification read while it is the reported source.
- R12: `irq` is 1 exactly when an enabled source is pending and modem control bit 3 is 1. With that bit at 0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rx_load | input | 1 | Received byte valid pulse |
| rx_data | input | 8 | Received byte |
| rx_err | input | 4 | Line error pulses: overrun, parity, framing, break |
| tx_done | input | 1 | Transmitter took the holding byte |
| modem_in | input | 4 | Modem input levels |
| tx_load | output | 1 | One-cycle pulse, new transmit byte |
| tx_data | output | 8 | Transmit holding byte |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control register |
| fifo_ctrl | output | 8 | FIFO control register |
| modem_ctrl | output | 5 | Modem control register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is several interrupt sources pending at once, because the reported code must then step down the priority order as each source is cleared by its own access. The stimulus fires a received byte and a line error in the same cycle, and a modem input change together with a transmit-done pulse. It then reads the identification, line status, receive and modem status registers in turn and checks the code after each read. The bank bit is toggled between divisor accesses to show that the low addresses leave the transmitter and the enable register untouched while the bank bit is set.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int DIV_W    = 2 * DATA_W;
    localparam int IER_W    = 4;
    localparam int MCR_W    = 5;
    localparam int ERR_W    = 4;
    localparam int MODEM_W  = 4;
    localparam int CODE_W   = 4;
    localparam int BANK_BIT = 7;
    localparam int GATE_BIT = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA  = 3'd0,
        A_IEN   = 3'd1,
        A_IDENT = 3'd2,
        A_LCTL  = 3'd3,
        A_MCTL  = 3'd4,
        A_LSTAT = 3'd5,
        A_MSTAT = 3'd6,
        A_SCR   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic thr;
        logic rbr;
        logic div_lo;
        logic div_hi;
        logic ien;
        logic ident;
        logic fctl;
        logic lctl;
        logic mctl;
        logic lstat;
        logic mstat;
        logic scr;
    } reg_sel_t;

    typedef enum logic [CODE_W-1:0] {
        CODE_MODEM = 4'h0,
        CODE_NONE  = 4'h1,
        CODE_TXE   = 4'h2,
        CODE_RXD   = 4'h4,
        CODE_LINE  = 4'h6
    } ident_code_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic txe;
        logic modem;
    } irq_src_t;

    function automatic ident_code_e pick_source(irq_src_t p);
        if (p.line)       return CODE_LINE;
        else if (p.rxd)   return CODE_RXD;
        else if (p.txe)   return CODE_TXE;
        else if (p.modem) return CODE_MODEM;
        else              return CODE_NONE;
    endfunction

endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uart_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank,
    output reg_sel_t          sel
);
    always_comb begin
        sel = '0;
        case (reg_addr_e'(addr))
            A_DATA: begin
                if (bank) begin
                    sel.div_lo = 1'b1;
                end else begin
                    sel.thr = 1'b1;
                    sel.rbr = 1'b1;
                end
            end
            A_IEN: begin
                if (bank) sel.div_hi = 1'b1;
                else      sel.ien    = 1'b1;
            end
            A_IDENT: begin
                sel.ident = 1'b1;
                sel.fctl  = 1'b1;
            end
            A_LCTL:  sel.lctl  = 1'b1;
            A_MCTL:  sel.mctl  = 1'b1;
            A_LSTAT: sel.lstat = 1'b1;
            A_MSTAT: sel.mstat = 1'b1;
            A_SCR:   sel.scr   = 1'b1;
            default: sel = '0;
        endcase
    end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              tx_done,
    input  logic              thr_wr,
    input  logic              rbr_rd,
    input  logic              lstat_rd,
    input  logic              lstat_wr,
    input  logic [ERR_W-1:0]  err_wdata,
    output logic [DATA_W-1:0] rbr,
    output logic [DATA_W-1:0] lstat,
    output logic              data_ready,
    output logic              err_any
);
    logic [ERR_W-1:0] err_q;
    logic             thr_empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr         <= '0;
            data_ready  <= 1'b0;
            err_q       <= '0;
            thr_empty_q <= 1'b1;
        end else begin
            if (rx_load) rbr <= rx_data;
            data_ready <= (data_ready & ~rbr_rd) | rx_load;
            if (lstat_wr)      err_q <= err_wdata | rx_err;
            else if (lstat_rd) err_q <= rx_err;
            else               err_q <= err_q | rx_err;
            if (thr_wr)        thr_empty_q <= 1'b0;
            else if (tx_done)  thr_empty_q <= 1'b1;
        end
    end

    assign lstat   = {1'b0, thr_empty_q, thr_empty_q, err_q, data_ready};
    assign err_any = |err_q;
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import uart_regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               mstat_rd,
    input  logic               mstat_wr,
    input  logic [MODEM_W-1:0] delta_wdata,
    output logic [DATA_W-1:0]  mstat,
    output logic               delta_any
);
    logic [MODEM_W-1:0] prev_q;
    logic [MODEM_W-1:0] delta_q;
    logic [MODEM_W-1:0] change;

    assign change = modem_in ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q <= modem_in;
            if (mstat_wr)      delta_q <= delta_wdata | change;
            else if (mstat_rd) delta_q <= change;
            else               delta_q <= delta_q | change;
        end
    end

    assign mstat     = {modem_in, delta_q};
    assign delta_any = |delta_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_regbank_pkg::*;
(
    input  irq_src_t          pend,
    input  logic              gate,
    output ident_code_e       code,
    output logic [DATA_W-1:0] ident,
    output logic              irq
);
    assign code  = pick_source(pend);
    assign ident = {{(DATA_W-CODE_W){1'b0}}, code};
    assign irq   = gate & (|pend);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                rx_load,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic [ERR_W-1:0]    rx_err,
    input  logic                tx_done,
    input  logic [MODEM_W-1:0]  modem_in,
    output logic                tx_load,
    output logic [DATA_W-1:0]   tx_data,
    output logic [DIV_W-1:0]    divisor,
    output logic [DATA_W-1:0]   line_ctrl,
    output logic [DATA_W-1:0]   fifo_ctrl,
    output logic [MCR_W-1:0]    modem_ctrl,
    output logic                irq
);
    reg_sel_t          sel;
    logic [DATA_W-1:0] lctl_q, fctl_q, scr_q, div_lo_q, div_hi_q, tx_q;
    logic [IER_W-1:0]  ien_q;
    logic [MCR_W-1:0]  mctl_q;
    logic              tx_load_q, txe_pend_q;
    logic [DATA_W-1:0] rbr, lstat, mstat, ident;
    logic              line_dr, err_any, delta_any;
    irq_src_t          pend;
    ident_code_e       code;

    logic bank;
    assign bank = lctl_q[BANK_BIT];

    uart_addr_decode u_dec (.addr(addr), .bank(bank), .sel(sel));

    logic wr_thr, wr_dlo, wr_dhi, wr_ien, wr_fctl, wr_lctl, wr_mctl, wr_lstat, wr_mstat, wr_scr;
    logic rd_rbr, rd_ident, rd_lstat, rd_mstat;
    assign wr_thr   = wr_en & sel.thr;
    assign wr_dlo   = wr_en & sel.div_lo;
    assign wr_dhi   = wr_en & sel.div_hi;
    assign wr_ien   = wr_en & sel.ien;
    assign wr_fctl  = wr_en & sel.fctl;
    assign wr_lctl  = wr_en & sel.lctl;
    assign wr_mctl  = wr_en & sel.mctl;
    assign wr_lstat = wr_en & sel.lstat;
    assign wr_mstat = wr_en & sel.mstat;
    assign wr_scr   = wr_en & sel.scr;
    assign rd_rbr   = rd_en & sel.rbr;
    assign rd_ident = rd_en & sel.ident;
    assign rd_lstat = rd_en & sel.lstat;
    assign rd_mstat = rd_en & sel.mstat;

    always_ff @(posedge clk) begin
        if (rst) begin
            lctl_q     <= '0;
            fctl_q     <= '0;
            scr_q      <= '0;
            div_lo_q   <= '0;
            div_hi_q   <= '0;
            tx_q       <= '0;
            ien_q      <= '0;
            mctl_q     <= '0;
            tx_load_q  <= 1'b0;
            txe_pend_q <= 1'b0;
        end else begin
            tx_load_q <= wr_thr;
            if (wr_thr)   tx_q     <= wdata;
            if (wr_dlo)   div_lo_q <= wdata;
            if (wr_dhi)   div_hi_q <= wdata;
            if (wr_ien)   ien_q    <= wdata[IER_W-1:0];
            if (wr_fctl)  fctl_q   <= wdata;
            if (wr_lctl)  lctl_q   <= wdata;
            if (wr_mctl)  mctl_q   <= wdata[MCR_W-1:0];
            if (wr_scr)   scr_q    <= wdata;
            if (tx_done)
                txe_pend_q <= 1'b1;
            else if (wr_thr || (rd_ident && code == CODE_TXE))
                txe_pend_q <= 1'b0;
        end
    end

    uart_line_status u_lsr (
        .clk(clk), .rst(rst),
        .rx_load(rx_load), .rx_data(rx_data), .rx_err(rx_err),
        .tx_done(tx_done), .thr_wr(wr_thr), .rbr_rd(rd_rbr),
        .lstat_rd(rd_lstat), .lstat_wr(wr_lstat),
        .err_wdata(wdata[ERR_W:1]),
        .rbr(rbr), .lstat(lstat), .data_ready(line_dr), .err_any(err_any)
    );

    uart_modem_status u_msr (
        .clk(clk), .rst(rst), .modem_in(modem_in),
        .mstat_rd(rd_mstat), .mstat_wr(wr_mstat),
        .delta_wdata(wdata[MODEM_W-1:0]),
        .mstat(mstat), .delta_any(delta_any)
    );

    assign pend.line  = err_any    & ien_q[2];
    assign pend.rxd   = line_dr    & ien_q[0];
    assign pend.txe   = txe_pend_q & ien_q[1];
    assign pend.modem = delta_any  & ien_q[3];

    uart_irq_prio u_prio (
        .pend(pend), .gate(mctl_q[GATE_BIT]),
        .code(code), .ident(ident), .irq(irq)
    );

    always_comb begin
        rdata = '0;
        if (sel.rbr)         rdata = rbr;
        else if (sel.div_lo) rdata = div_lo_q;
        else if (sel.div_hi) rdata = div_hi_q;
        else if (sel.ien)    rdata = {{(DATA_W-IER_W){1'b0}}, ien_q};
        else if (sel.ident)  rdata = ident;
        else if (sel.lctl)   rdata = lctl_q;
        else if (sel.mctl)   rdata = {{(DATA_W-MCR_W){1'b0}}, mctl_q};
        else if (sel.lstat)  rdata = lstat;
        else if (sel.mstat)  rdata = mstat;
        else if (sel.scr)    rdata = scr_q;
    end

    assign tx_load    = tx_load_q;
    assign tx_data    = tx_q;
    assign divisor    = {div_hi_q, div_lo_q};
    assign line_ctrl  = lctl_q;
    assign fifo_ctrl  = fctl_q;
    assign modem_ctrl = mctl_q;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
    import uart_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rx_load,
    input logic [DATA_W-1:0] line_ctrl,
    input logic [MCR_W-1:0]  modem_ctrl,
    input logic              irq,
    input logic              tx_load,
    input logic [DATA_W-1:0] tx_data,
    input logic [DIV_W-1:0]  divisor,
    input logic              line_dr
);
    // R1
    reset_val_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (divisor == '0 && !irq && !tx_load));

    // R2
    thr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && !line_ctrl[BANK_BIT]) |=> (tx_load && tx_data == $past(wdata)));

    // R3
    div_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && line_ctrl[BANK_BIT]) |=> (!tx_load && divisor[DATA_W-1:0] == $past(wdata)));

    // R6
    dr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd0 && !line_ctrl[BANK_BIT] && !rx_load) |=> !line_dr);

    // R9
    ident_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd2 && modem_ctrl[GATE_BIT] && !irq) |-> rdata == 8'h01);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !modem_ctrl[GATE_BIT] |-> !irq);
endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_load(rx_load), .line_ctrl(line_ctrl),
    .modem_ctrl(modem_ctrl), .irq(irq), .tx_load(tx_load), .tx_data(tx_data),
    .divisor(divisor), .line_dr(line_dr)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rx_load = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [3:0]  rx_err = '0;
    logic        tx_done = 1'b0;
    logic [3:0]  modem_in = '0;
    logic        tx_load;
    logic [7:0]  tx_data;
    logic [15:0] divisor;
    logic [7:0]  line_ctrl, fifo_ctrl;
    logic [4:0]  modem_ctrl;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_regbank u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_load(rx_load), .rx_data(rx_data),
        .rx_err(rx_err), .tx_done(tx_done), .modem_in(modem_in),
        .tx_load(tx_load), .tx_data(tx_data), .divisor(divisor),
        .line_ctrl(line_ctrl), .fifo_ctrl(fifo_ctrl), .modem_ctrl(modem_ctrl),
        .irq(irq)
    );

    // entry: {write, addr, data, requirement}; a read compares data
    localparam int NV = 20;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 3'd7, 8'hA5, 4'd5},   // R5 scratch
        {1'b1, 3'd3, 8'h80, 4'd5},   // bank bit on
        {1'b1, 3'd0, 8'h34, 4'd3},   // R3 divisor low
        {1'b1, 3'd1, 8'h12, 4'd3},   // divisor high
        {1'b0, 3'd0, 8'h34, 4'd3},
        {1'b0, 3'd1, 8'h12, 4'd3},
        {1'b0, 3'd7, 8'hA5, 4'd5},   // scratch with bank on
        {1'b0, 3'd3, 8'h80, 4'd5},
        {1'b1, 3'd3, 8'h03, 4'd5},   // bank off
        {1'b0, 3'd0, 8'h00, 4'd2},   // empty receive buffer
        {1'b0, 3'd1, 8'h00, 4'd3},   // enable untouched by divisor writes
        {1'b1, 3'd1, 8'h0F, 4'd10},
        {1'b0, 3'd1, 8'h0F, 4'd10},
        {1'b1, 3'd4, 8'h08, 4'd5},
        {1'b0, 3'd4, 8'h08, 4'd5},
        {1'b1, 3'd2, 8'hC7, 4'd4},   // R4 fifo control write
        {1'b0, 3'd2, 8'h01, 4'd4},   // read gives identification
        {1'b0, 3'd5, 8'h60, 4'd5},
        {1'b0, 3'd6, 8'h00, 4'd5},
        {1'b0, 3'd3, 8'h03, 4'd5}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2 check(req, {8'h00, rdata}, {8'h00, exp});
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic rl, input logic [7:0] rd, input logic [3:0] er, input logic td);
        @(negedge clk);
        rx_load = rl; rx_data = rd; rx_err = er; tx_done = td;
        @(posedge clk); #1;
        rx_load = 1'b0; rx_err = '0; tx_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 divisor", divisor, 16'h0000);
        check("R1 tx_load", {15'd0, tx_load}, 16'd0);
        check("R1 ctrl", {line_ctrl, fifo_ctrl}, 16'h0000);
        check("R1 mctl", {11'd0, modem_ctrl}, 16'd0);
        reg_rd(3'd2, 8'h01, "R1 ident");
        reg_rd(3'd5, 8'h60, "R1 lstat");
        reg_rd(3'd7, 8'h00, "R1 scratch");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][15]) reg_wr(VEC[i][14:12], VEC[i][11:4]);
            else reg_rd(VEC[i][14:12], VEC[i][11:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));
        end
        check("R3 divisor port", divisor, 16'h1234);
        check("R4 fifo_ctrl", {8'h00, fifo_ctrl}, 16'h00C7);

        // R2 transmit holding write
        reg_wr(3'd0, 8'h5A);
        check("R2 tx_load", {15'd0, tx_load}, 16'd1);
        check("R2 tx_data", {8'h00, tx_data}, 16'h005A);
        reg_rd(3'd5, 8'h00, "R2 lstat busy");
        check("R2 pulse ends", {15'd0, tx_load}, 16'd0);

        // R11 holding-empty source
        pulse(1'b0, 8'h00, 4'h0, 1'b1);
        check("R11 irq set", {15'd0, irq}, 16'd1);
        reg_rd(3'd5, 8'h60, "R2 lstat empty");
        reg_rd(3'd2, 8'h02, "R11 ident");
        check("R11 read clears", {15'd0, irq}, 16'd0);
        reg_rd(3'd2, 8'h01, "R11 ident idle");
        pulse(1'b0, 8'h00, 4'h0, 1'b1);
        reg_wr(3'd0, 8'h11);
        check("R11 write clears", {15'd0, irq}, 16'd0);
        pulse(1'b0, 8'h00, 4'h0, 1'b1);
        reg_rd(3'd2, 8'h02, "R11 ident again");

        // R6 receive path
        pulse(1'b1, 8'hC3, 4'h0, 1'b0);
        reg_rd(3'd5, 8'h61, "R6 data ready");
        reg_rd(3'd2, 8'h04, "R9 rx code");
        reg_rd(3'd0, 8'hC3, "R6 rbr");
        reg_rd(3'd5, 8'h60, "R6 dr cleared");
        check("R6 irq off", {15'd0, irq}, 16'd0);

        // R7 and R9: error outranks data
        pulse(1'b1, 8'h3C, 4'b0010, 1'b0);
        reg_rd(3'd2, 8'h06, "R9 line code");
        reg_rd(3'd5, 8'h65, "R7 parity bit");
        reg_rd(3'd2, 8'h04, "R9 step to rx");
        reg_rd(3'd0, 8'h3C, "R6 rbr 2");
        reg_rd(3'd2, 8'h01, "R9 none");

        // R8 modem change
        @(negedge clk); modem_in = 4'b0101;
        @(posedge clk); #1;
        check("R8 irq", {15'd0, irq}, 16'd1);
        reg_rd(3'd2, 8'h00, "R9 modem code");
        reg_rd(3'd6, 8'h55, "R8 mstat");
        reg_rd(3'd6, 8'h50, "R8 delta cleared");
        reg_rd(3'd2, 8'h01, "R8 ident idle");

        // R9 holding empty outranks modem change
        @(negedge clk); modem_in = 4'b0000; tx_done = 1'b1;
        @(posedge clk); #1; tx_done = 1'b0;
        reg_rd(3'd2, 8'h02, "R9 txe over modem");
        reg_rd(3'd2, 8'h00, "R9 then modem");
        reg_rd(3'd6, 8'h05, "R8 falling deltas");
        reg_rd(3'd2, 8'h01, "R9 clear");

        // R10 masking
        reg_wr(3'd1, 8'h00);
        pulse(1'b1, 8'h77, 4'h0, 1'b0);
        reg_rd(3'd2, 8'h01, "R10 masked code");
        check("R10 masked irq", {15'd0, irq}, 16'd0);
        reg_rd(3'd5, 8'h61, "R10 dr still set");
        reg_wr(3'd1, 8'h01);
        reg_rd(3'd2, 8'h04, "R10 unmasked");
        reg_rd(3'd0, 8'h77, "R10 rbr");

        // R12 output gate
        pulse(1'b1, 8'h88, 4'h0, 1'b0);
        check("R12 irq on", {15'd0, irq}, 16'd1);
        reg_wr(3'd4, 8'h00);
        check("R12 gated", {15'd0, irq}, 16'd0);
        reg_rd(3'd2, 8'h04, "R12 code kept");
        reg_wr(3'd4, 8'h08);
        check("R12 ungated", {15'd0, irq}, 16'd1);
        reg_rd(3'd0, 8'h88, "R12 rbr");
        check("R12 cleared", {15'd0, irq}, 16'd0);

        // R3 bank bit keeps transmitter and enable apart
        reg_wr(3'd3, 8'h80);
        reg_wr(3'd1, 8'h55);
        reg_wr(3'd0, 8'h99);
        check("R3 no tx_load", {15'd0, tx_load}, 16'd0);
        check("R3 divisor", divisor, 16'h5599);
        reg_wr(3'd3, 8'h03);
        reg_rd(3'd1, 8'h01, "R3 enable kept");
        reg_rd(3'd5, 8'h60, "R3 holding still empty");

        // R5 status writes
        reg_wr(3'd5, 8'h1E);
        reg_rd(3'd5, 8'h7E, "R5 lstat write");
        reg_rd(3'd5, 8'h60, "R7 read clears");
        reg_wr(3'd6, 8'h0A);
        reg_rd(3'd6, 8'h0A, "R5 mstat write");
        reg_rd(3'd6, 8'h00, "R8 read clears");
        reg_wr(3'd4, 8'hFF);
        reg_rd(3'd4, 8'h1F, "R5 mctl width");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule